// File: doc/BRIEF.md
# Per-Vector Interrupt Message Table with Pending Bits

This block holds a table of interrupt vectors, each with its own 64-bit message address, 32-bit message data word and mask bit, behind a 32-bit register read/write port. Vector numbers need not be contiguous, and every vector can be steered to a different processor by its own address. A second region, selected by `regSel`, exposes a read-only pending-bit array with one bit per vector.

An interrupt request on a vector always sets that vector's pending bit. A sender scans the pending bits. It picks the lowest-indexed vector that is pending and not masked, provided the function-wide mask is clear and the output slot is free. It copies that entry's address and data into an output message register, clears the pending bit and offers the message on a valid/ready channel. A masked vector therefore keeps its request in the pending array, and the message goes out as soon as the mask is cleared. The region locators and the encoded table size are exposed as constant outputs for the capability structure.

Top module: `msix_vec_table`

## Requirements
- R1: After reset, every entry's mask bit is 1, all address and data words read 0, all pending bits are 0 and `msgValid` is 0.
- R2: With `regSel`=0, entry e word w sits at byte offset e*16 + w*4. Word 0 is address low, word 1 is address high, word 2 is data, and word 3 is control, where bit 0 is the mask and all other bits read 0. A write takes effect at its clock edge. Read data and `regRdValid` appear after the edge that samples `regRdEn`.
- R3: A request on an unmasked vector, with the function-wide mask clear and the output free, raises `msgValid` after the second clock edge from the request. `msgAddr` is {address high, address low} of that entry, `msgData` is its data word, and the pending bit is cleared.
- R4: A request on a vector whose mask bit is 1 sets its pending bit and produces no message.
- R5: While `fnMask` is 1, no message is issued and requests only set pending bits.
- R6: Clearing a vector's mask, or clearing `fnMask`, while its bit is pending issues its message after the next clock edge and clears the pending bit.
- R7: With `regSel`=1, pending bit v is bit v%64 of 64-bit word v/64, read as two 32-bit halves at byte offsets 0 (bits 31:0) and 4 (bits 63:32) of that word. Writes to this region are ignored.
- R8: While `msgValid` is 1 and `msgReady` is 0, `msgValid`, `msgAddr` and `msgData` hold their values.
- R9: When several vectors are eligible, the lowest-indexed one is sent first. A new message may load on the same edge that the previous one is accepted.
- R10: `tableLoc` is the table offset with the region index in bits 2:0, `pbaLoc` is the same for the pending array, and `tableSize` is the vector count minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regSel | input | 1 | 0 selects the vector table, 1 the pending array |
| regAddr | input | ADDR_W | Byte offset within the selected region |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered |
| regRdValid | output | 1 | Read data valid |
| irqValid | input | 1 | Interrupt request strobe |
| irqVec | input | VEC_W | Requested vector index |
| fnMask | input | 1 | Function-wide mask |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Message accepted by the sink |
| msgAddr | output | 64 | Message write address |
| msgData | output | 32 | Message write data |
| tableLoc | output | 32 | Table offset with region index in bits 2:0 |
| pbaLoc | output | 32 | Pending array offset with region index in bits 2:0 |
| tableSize | output | 11 | Number of vectors minus one |

## Verification
A register write lands at its own edge, and read data is due one edge after the read strobe. A message is due two edges after a request on an open vector. It is due one edge after a mask or `fnMask` is cleared, or after `msgReady` accepts the previous message. The bench drives every input at the falling edge and checks outputs at the falling edge after the exact rising edge it has counted. It also checks for the absence of `msgValid` in the cycle before a message is due. Stability under back-pressure is checked on several consecutive cycles.

// File: rtl/msix_vec_pkg.sv
package msix_vec_pkg;
  localparam int MAX_VEC_W = 11;

  typedef struct packed {
    logic                 load;
    logic [MAX_VEC_W-1:0] vec;
  } launchStrobe_t;
endpackage

// File: rtl/msix_vec_datapath.sv
module msix_vec_datapath
  import msix_vec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 16,
  parameter int VEC_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic               regSel,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               regRdValid,
  input  logic [NUM_VEC-1:0] pend,
  input  launchStrobe_t      strobe,
  output logic [NUM_VEC-1:0] vecMask,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData
);
  localparam int ENT_W = ADDR_W - 4;
  localparam logic [ENT_W:0] VEC_LIMIT = (ENT_W+1)'(NUM_VEC);

  logic [31:0] addrLo [NUM_VEC];
  logic [31:0] addrHi [NUM_VEC];
  logic [31:0] dataW  [NUM_VEC];

  logic [ENT_W-1:0] entryIdx;
  logic             entryOk;
  logic [VEC_W-1:0] eIdx;
  logic [VEC_W-1:0] loadIdx;
  logic [31:0]      tableWord;
  logic [31:0]      pbaWord;

  assign entryIdx = regAddr[ADDR_W-1:4];
  assign entryOk  = {1'b0, entryIdx} < VEC_LIMIT;
  assign eIdx     = entryIdx[VEC_W-1:0];
  assign loadIdx  = strobe.vec[VEC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        addrLo[i] <= '0;
        addrHi[i] <= '0;
        dataW[i]  <= '0;
      end
      vecMask <= '1;
    end else if (regWrEn && !regSel && entryOk) begin
      case (regAddr[3:2])
        2'd0: addrLo[eIdx]  <= regWrData;
        2'd1: addrHi[eIdx]  <= regWrData;
        2'd2: dataW[eIdx]   <= regWrData;
        default: vecMask[eIdx] <= regWrData[0];
      endcase
    end
  end

  always_comb begin
    tableWord = '0;
    if (entryOk) begin
      case (regAddr[3:2])
        2'd0: tableWord = addrLo[eIdx];
        2'd1: tableWord = addrHi[eIdx];
        2'd2: tableWord = dataW[eIdx];
        default: tableWord = {31'd0, vecMask[eIdx]};
      endcase
    end
  end

  always_comb begin
    pbaWord = '0;
    for (int i = 0; i < 32; i++) begin
      int b;
      b = int'(regAddr[ADDR_W-1:3]) * 64 + int'(regAddr[2]) * 32 + i;
      if (b < NUM_VEC) pbaWord[i] = pend[b[VEC_W-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdValid <= 1'b0;
      regRdData  <= '0;
    end else begin
      regRdValid <= regRdEn;
      if (regRdEn) regRdData <= regSel ? pbaWord : tableWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgAddr <= '0;
      msgData <= '0;
    end else if (strobe.load) begin
      msgAddr <= {addrHi[loadIdx], addrLo[loadIdx]};
      msgData <= dataW[loadIdx];
    end
  end

  // R2: read strobe always yields valid data on the next cycle
  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid);
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msix_vec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               irqValid,
  input  logic [VEC_W-1:0]   irqVec,
  input  logic               fnMask,
  input  logic [NUM_VEC-1:0] vecMask,
  input  logic               msgReady,
  output logic [NUM_VEC-1:0] pend,
  output logic               msgValid,
  output launchStrobe_t      strobe
);
  localparam logic [VEC_W:0] VEC_LIMIT = (VEC_W+1)'(NUM_VEC);

  logic [NUM_VEC-1:0] eligible;
  logic               anyEligible;
  logic               slotFree;
  int                 pickIdx;

  assign eligible    = pend & ~vecMask;
  assign anyEligible = |eligible;
  assign slotFree    = !msgValid || msgReady;

  always_comb begin
    pickIdx = 0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (eligible[i]) pickIdx = i;
    end
  end

  always_comb begin
    strobe.load = !fnMask && anyEligible && slotFree;
    strobe.vec  = MAX_VEC_W'(pickIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
    end else begin
      for (int i = 0; i < NUM_VEC; i++) begin
        if (irqValid && {1'b0, irqVec} < VEC_LIMIT && int'(irqVec) == i)
          pend[i] <= 1'b1;
        else if (strobe.load && pickIdx == i)
          pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              msgValid <= 1'b0;
    else if (strobe.load)   msgValid <= 1'b1;
    else if (msgReady)      msgValid <= 1'b0;
  end

  // R3: a launch is followed by a valid message
  a_r3_load_then_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> msgValid);
  // R3: a launched vector's pending bit is cleared unless re-requested
  a_r3_launch_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !(irqValid && int'(irqVec) == int'(strobe.vec))
    |=> !pend[$past(strobe.vec[VEC_W-1:0])]);
  // R4: the datapath's mask state never allows a masked launch
  a_r4_masked_never_sent: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !vecMask[strobe.vec[VEC_W-1:0]]);
  // R5: function-wide mask blocks every launch
  a_r5_fn_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    fnMask |-> !strobe.load);
endmodule

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_vec_pkg::*;
#(
  parameter int          NUM_VEC   = 8,
  parameter int          ADDR_W    = 16,
  parameter logic [31:0] TABLE_OFS = 32'h0000_2000,
  parameter logic [2:0]  TABLE_BIR = 3'd2,
  parameter logic [31:0] PBA_OFS   = 32'h0000_3000,
  parameter logic [2:0]  PBA_BIR   = 3'd2,
  localparam int         VEC_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              regRdValid,
  input  logic              irqValid,
  input  logic [VEC_W-1:0]  irqVec,
  input  logic              fnMask,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [63:0]       msgAddr,
  output logic [31:0]       msgData,
  output logic [31:0]       tableLoc,
  output logic [31:0]       pbaLoc,
  output logic [10:0]       tableSize
);
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] vecMask;
  launchStrobe_t      strobe;

  assign tableLoc  = {TABLE_OFS[31:3], TABLE_BIR};
  assign pbaLoc    = {PBA_OFS[31:3], PBA_BIR};
  assign tableSize = 11'(NUM_VEC - 1);

  msix_vec_datapath #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) i_dp (
    .clk, .rstN, .regWrEn, .regRdEn, .regSel, .regAddr, .regWrData,
    .regRdData, .regRdValid, .pend, .strobe, .vecMask, .msgAddr, .msgData
  );

  msix_vec_ctrl #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) i_ctrl (
    .clk, .rstN, .irqValid, .irqVec, .fnMask, .vecMask, .msgReady,
    .pend, .msgValid, .strobe
  );

  // R8: a stalled message keeps its content
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgAddr) && $stable(msgData));
endmodule

// File: tb/test_msix_vec_table.sv
`timescale 1ns/1ps
module test_msix_vec_table;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, regSel = 1'b0;
  logic [15:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regRdValid;
  logic        irqValid = 1'b0;
  logic [2:0]  irqVec = '0;
  logic        fnMask = 1'b0;
  logic        msgValid;
  logic        msgReady = 1'b1;
  logic [63:0] msgAddr;
  logic [31:0] msgData;
  logic [31:0] tableLoc, pbaLoc;
  logic [10:0] tableSize;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  msix_vec_table i_msix_vec_table (
    .clk, .rstN, .regWrEn, .regRdEn, .regSel, .regAddr, .regWrData,
    .regRdData, .regRdValid, .irqValid, .irqVec, .fnMask, .msgValid,
    .msgReady, .msgAddr, .msgData, .tableLoc, .pbaLoc, .tableSize
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(logic sel, logic [15:0] addr, logic [31:0] data);
    regWrEn = 1'b1; regSel = sel; regAddr = addr; regWrData = data;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic sel, logic [15:0] addr, output logic [31:0] data);
    regRdEn = 1'b1; regSel = sel; regAddr = addr;
    step();
    regRdEn = 1'b0;
    check("R2 rd valid", 64'(regRdValid), 64'd1);
    data = regRdData;
  endtask

  task automatic irqPulse(logic [2:0] v);
    irqValid = 1'b1; irqVec = v;
    step();
    irqValid = 1'b0;
  endtask

  task automatic expectMsg(string req, logic [63:0] a, logic [31:0] d);
    check({req, " valid"}, 64'(msgValid), 64'd1);
    check({req, " addr"}, msgAddr, a);
    check({req, " data"}, 64'(msgData), 64'(d));
  endtask

  task automatic test_reset();
    logic [31:0] rd;
    check("R1 msgValid", 64'(msgValid), 64'd0);
    regRead(1'b0, 16'h000C, rd); check("R1 mask e0", 64'(rd), 64'd1);
    regRead(1'b0, 16'h007C, rd); check("R1 mask e7", 64'(rd), 64'd1);
    regRead(1'b0, 16'h0030, rd); check("R1 addrLo e3", 64'(rd), 64'd0);
    regRead(1'b0, 16'h0038, rd); check("R1 data e3", 64'(rd), 64'd0);
    regRead(1'b1, 16'h0000, rd); check("R1 pending", 64'(rd), 64'd0);
    check("R10 tableLoc", 64'(tableLoc), 64'h2002);
    check("R10 pbaLoc", 64'(pbaLoc), 64'h3002);
    check("R10 tableSize", 64'(tableSize), 64'd7);
  endtask

  task automatic test_table_rw();
    logic [31:0] rd;
    regWrite(1'b0, 16'h0020, 32'hFEE0_1000);
    regWrite(1'b0, 16'h0024, 32'h0);
    regWrite(1'b0, 16'h0028, 32'h41);
    regWrite(1'b0, 16'h002C, 32'hFFFF_FFFE);
    regWrite(1'b0, 16'h0050, 32'hFEE0_2000);
    regWrite(1'b0, 16'h0054, 32'h1);
    regWrite(1'b0, 16'h0058, 32'h55);
    regWrite(1'b0, 16'h005C, 32'h0);
    regWrite(1'b0, 16'h007C, 32'hFFFF_FFFF);
    regRead(1'b0, 16'h0020, rd); check("R2 addrLo e2", 64'(rd), 64'hFEE0_1000);
    regRead(1'b0, 16'h0054, rd); check("R2 addrHi e5", 64'(rd), 64'h1);
    regRead(1'b0, 16'h0028, rd); check("R2 data e2", 64'(rd), 64'h41);
    regRead(1'b0, 16'h002C, rd); check("R2 ctrl e2", 64'(rd), 64'h0);
    regRead(1'b0, 16'h007C, rd); check("R2 ctrl e7 upper bits", 64'(rd), 64'h1);
  endtask

  task automatic test_unmasked();
    logic [31:0] rd;
    irqPulse(3'd2);
    check("R3 not before 2nd edge", 64'(msgValid), 64'd0);
    step();
    expectMsg("R3 msg v2", 64'h0000_0000_FEE0_1000, 32'h41);
    step();
    check("R3 consumed", 64'(msgValid), 64'd0);
    regRead(1'b1, 16'h0000, rd); check("R3 pending cleared", 64'(rd), 64'h0);
  endtask

  task automatic test_masked_then_unmask();
    logic [31:0] rd;
    irqPulse(3'd3);
    repeat (3) begin
      step();
      check("R4 no msg masked", 64'(msgValid), 64'd0);
    end
    regRead(1'b1, 16'h0000, rd); check("R4 pending v3", 64'(rd), 64'h8);
    regWrite(1'b0, 16'h0030, 32'hFEE0_3000);
    regWrite(1'b0, 16'h0038, 32'h63);
    regWrite(1'b0, 16'h003C, 32'h0);
    check("R6 not yet", 64'(msgValid), 64'd0);
    step();
    expectMsg("R6 msg v3", 64'h0000_0000_FEE0_3000, 32'h63);
    step();
    regRead(1'b1, 16'h0000, rd); check("R6 pending cleared", 64'(rd), 64'h0);
  endtask

  task automatic test_fn_mask();
    logic [31:0] rd;
    fnMask = 1'b1;
    irqPulse(3'd2);
    repeat (3) begin
      step();
      check("R5 held by fnMask", 64'(msgValid), 64'd0);
    end
    regRead(1'b1, 16'h0000, rd); check("R5 pending v2", 64'(rd), 64'h4);
    fnMask = 1'b0;
    step();
    expectMsg("R6 fnMask release", 64'h0000_0000_FEE0_1000, 32'h41);
    step();
    check("R6 consumed", 64'(msgValid), 64'd0);
  endtask

  task automatic test_priority_backpressure();
    logic [31:0] rd;
    msgReady = 1'b0;
    fnMask = 1'b1;
    irqPulse(3'd5);
    irqPulse(3'd2);
    regRead(1'b1, 16'h0000, rd); check("R7 pending v2 v5", 64'(rd), 64'h24);
    fnMask = 1'b0;
    step();
    expectMsg("R9 lowest first", 64'h0000_0000_FEE0_1000, 32'h41);
    repeat (3) begin
      step();
      expectMsg("R8 stalled hold", 64'h0000_0000_FEE0_1000, 32'h41);
    end
    regRead(1'b1, 16'h0000, rd); check("R9 v5 still pending", 64'(rd), 64'h20);
    msgReady = 1'b1;
    step();
    expectMsg("R9 back-to-back v5", 64'h0000_0001_FEE0_2000, 32'h55);
    step();
    check("R9 drained", 64'(msgValid), 64'd0);
  endtask

  task automatic test_pba_readonly();
    logic [31:0] rd;
    regWrite(1'b0, 16'h003C, 32'h1);
    irqPulse(3'd3);
    regWrite(1'b1, 16'h0000, 32'h0);
    regRead(1'b1, 16'h0000, rd); check("R7 write ignored", 64'(rd), 64'h8);
    regRead(1'b1, 16'h0004, rd); check("R7 upper half", 64'(rd), 64'h0);
    check("R4 masked again", 64'(msgValid), 64'd0);
    regWrite(1'b0, 16'h003C, 32'h0);
    step();
    expectMsg("R6 unmask v3", 64'h0000_0000_FEE0_3000, 32'h63);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_table_rw();
    test_unmasked();
    test_masked_then_unmask();
    test_fn_mask();
    test_priority_backpressure();
    test_pba_readonly();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule